// File: doc/BRIEF.md
# Channel Instruction Sequencer

This block carries out the single-word channel instructions of a peripheral processor. These are: input a word into A, output A, activate the channel, deactivate it, send a function code taken from A, and send a function code taken from the second instruction word. For each instruction it chooses one of four outcomes: complete the action, skip past it, exit it without effect, or hold the processor. It keeps the channel's active flag. It drives one-cycle active, inactive and function strobes toward the equipment. It writes the A register and returns the next program address.

An instruction is handed over on a valid/ready issue port. `instr_ready` is high only while no instruction is in flight. An instruction is taken on a cycle where both `instr_valid` and `instr_ready` are high, and the fields and `a_in` are captured on that edge. The instruction is then judged again on every clock until it finishes. On the finishing cycle `done` pulses together with `next_p`, and the block is ready again on the following cycle.

The data channel uses two valid/ready streams. On the input stream, `in_valid` means the channel is full, and `in_ready` is raised only while an input instruction is pending and the channel is active. On the output stream, `out_valid` is held with a stable word until `out_ready` is high. It is withdrawn only if the channel becomes inactive. Equipment may stall either stream for any number of cycles.

Two inputs stand for another processor or a deadstart acting on the channel. `ext_deact` clears the flag and `ext_act` sets it. Either one can release a held instruction.

Top module: `chctl_top`

## Requirements
- R1: `instr_ready` is high exactly when no instruction is in flight. The op codes are 0 input to A, 1 output from A, 2 activate, 3 deactivate, 4 function from A, and 5 function from m. Codes 6 and 7 finish at P+1 with no effect.
- R2: Input to A on an active channel with `in_valid` high accepts the word (`in_ready` high). It writes A with `in_data` in the low 12 bits and zeros in the upper 6 bits, and finishes at P+1. This holds whether the no-hang bit is set or clear.
- R3: Input to A with the no-hang bit clear holds the processor (`stall` high, `done` low) until the channel is both active and full.
- R4: Input to A with the no-hang bit set finishes at P+1 with A written to zero and no word taken. This happens if the channel is inactive at issue, or if it becomes inactive before a word arrives.
- R5: Output from A presents A[11:0] on `out_data` with `out_valid` while the channel is active. It finishes at P+1 on the cycle `out_ready` is high, and holds otherwise.
- R6: Activate on an inactive channel pulses `eq_act` for one cycle, sets the flag and finishes at P+1. If the channel is active and the no-hang bit is set, it finishes at P+1 with no pulse. If the channel is active and the bit is clear, it holds until the channel goes inactive and then activates.
- R7: Deactivate on an active channel pulses `eq_inact`, clears the flag and finishes at P+1. If the channel is inactive and the no-hang bit is set, it finishes at P+1 with no pulse. If the channel is inactive and the bit is clear, it holds until the channel becomes active and then deactivates.
- R8: A function on an inactive channel pulses `eq_func` for one cycle. The code on `eq_func_code` is A[11:0] for the A form, finishing at P+1, or the m word for the m form, finishing at P+2.
- R9: A function on an active channel holds when the no-hang bit is clear. When the bit is set it sends no pulse and finishes at P+1 for the A form or P+2 for the m form.
- R10: Every hold is judged again on each clock. `ext_deact` clears the flag on the next edge and takes priority over everything else. `ext_act` sets the flag unless the block itself clears it on that edge.
- R11: After reset the block is ready, the flag is clear, and `done`, `stall` and all strobes are low.
- R12: `done` and `stall` are never high together. At most one equipment strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block idle, instruction accepted when valid |
| instr_op | input | 3 | Instruction code (see R1) |
| instr_nohang | input | 1 | Bit 5 of the channel field: no-hang select |
| instr_m | input | 12 | Second instruction word (function from m) |
| instr_p | input | 12 | Address of the instruction |
| a_in | input | 18 | A register value at issue |
| a_wr | output | 1 | Write strobe for A |
| a_wdata | output | 18 | Value written into A |
| done | output | 1 | Instruction finished this cycle |
| next_p | output | 12 | Next program address, valid with done |
| stall | output | 1 | Processor held this cycle |
| in_valid | input | 1 | Channel full, word on in_data |
| in_ready | output | 1 | Word taken from channel |
| in_data | input | 12 | Channel input word |
| out_valid | output | 1 | Word presented to channel |
| out_ready | input | 1 | Channel takes the word |
| out_data | output | 12 | Channel output word |
| ext_act | input | 1 | External activation event |
| ext_deact | input | 1 | External deactivation event (other processor or deadstart) |
| ch_active | output | 1 | Channel active flag |
| eq_act | output | 1 | Active strobe to equipment |
| eq_inact | output | 1 | Inactive strobe to equipment |
| eq_func | output | 1 | Function strobe to equipment |
| eq_func_code | output | 12 | Function code, valid with eq_func |

## Verification
The assertions check, on every cycle, the relationships between the strobes and the flag. An active strobe occurs only on an inactive channel and leaves the flag set. An inactive strobe occurs only on an active channel and leaves the flag clear. Functions go out only on an inactive channel. An accepted input word always lands in A with its upper bits cleared, and an external deactivate always clears the flag. Which outcome each op, channel state and no-hang combination produces, the resulting P+1 or P+2, and the release of each kind of hold by a later channel event can only be shown by the bench's scenarios.

// File: rtl/chctl_pkg.sv
package chctl_pkg;
  typedef enum logic [2:0] {
    OP_IN_A   = 3'd0,
    OP_OUT_A  = 3'd1,
    OP_ACT    = 3'd2,
    OP_DEACT  = 3'd3,
    OP_FUNC_A = 3'd4,
    OP_FUNC_M = 3'd5
  } chop_e;

  typedef enum logic [1:0] {
    V_WAIT = 2'd0,
    V_DO   = 2'd1,
    V_SKIP = 2'd2,
    V_EXIT = 2'd3
  } verdict_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } seq_state_e;

  function automatic logic is_two_word(input logic [2:0] op);
    return op == OP_FUNC_M;
  endfunction
endpackage

// File: rtl/chctl_flag.sv
module chctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic own_set,
  input  logic own_clr,
  input  logic ext_act,
  input  logic ext_deact,
  output logic active
);
  // external deactivate wins, then the block's own actions, then external activate
  always_ff @(posedge clk) begin
    if (!rst_n)         active <= 1'b0;
    else if (ext_deact) active <= 1'b0;
    else if (own_clr)   active <= 1'b0;
    else if (own_set)   active <= 1'b1;
    else if (ext_act)   active <= 1'b1;
  end
endmodule

// File: rtl/chctl_judge.sv
module chctl_judge
  import chctl_pkg::*;
(
  input  logic [2:0] op,
  input  logic       nohang,
  input  logic       active,
  input  logic       full,
  input  logic       sink_ready,
  output verdict_e   verdict
);
  always_comb begin
    verdict = V_WAIT;
    unique case (op)
      OP_IN_A: begin
        if (active && full)        verdict = V_DO;
        else if (nohang && !active) verdict = V_EXIT;
      end
      OP_OUT_A: begin
        if (active && sink_ready)  verdict = V_DO;
      end
      OP_ACT: begin
        if (!active)               verdict = V_DO;
        else if (nohang)           verdict = V_SKIP;
      end
      OP_DEACT: begin
        if (active)                verdict = V_DO;
        else if (nohang)           verdict = V_SKIP;
      end
      OP_FUNC_A, OP_FUNC_M: begin
        if (!active)               verdict = V_DO;
        else if (nohang)           verdict = V_SKIP;
      end
      default:                     verdict = V_SKIP;
    endcase
  end
endmodule

// File: rtl/chctl_seq.sv
module chctl_seq
  import chctl_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 18,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [2:0]    instr_op,
  input  logic          instr_nohang,
  input  logic [W-1:0]  instr_m,
  input  logic [PW-1:0] instr_p,
  input  logic [AW-1:0] a_in,
  input  logic          active,
  input  logic [W-1:0]  in_data,
  input  verdict_e      verdict,
  output logic [2:0]    cur_op,
  output logic          cur_nohang,
  output logic          a_wr,
  output logic [AW-1:0] a_wdata,
  output logic          done,
  output logic [PW-1:0] next_p,
  output logic          stall,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          own_set,
  output logic          own_clr,
  output logic          eq_act,
  output logic          eq_inact,
  output logic          eq_func,
  output logic [W-1:0]  eq_func_code
);
  localparam int UPPER = AW - W;

  seq_state_e    state;
  logic [W-1:0]  m_q;
  logic [PW-1:0] p_q;
  logic [AW-1:0] a_q;
  logic          exec;
  logic          fin;

  assign exec        = (state == ST_EXEC);
  assign instr_ready = !exec;
  assign fin         = exec && (verdict != V_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_op     <= 3'd0;
      cur_nohang <= 1'b0;
      m_q        <= '0;
      p_q        <= '0;
      a_q        <= '0;
    end else if (!exec) begin
      if (instr_valid) begin
        state      <= ST_EXEC;
        cur_op     <= instr_op;
        cur_nohang <= instr_nohang;
        m_q        <= instr_m;
        p_q        <= instr_p;
        a_q        <= a_in;
      end
    end else if (fin) begin
      state <= ST_IDLE;
    end
  end

  always_comb begin
    done         = fin;
    stall        = exec && (verdict == V_WAIT);
    next_p       = p_q + (is_two_word(cur_op) ? PW'(2) : PW'(1));
    in_ready     = exec && (cur_op == OP_IN_A) && active;
    out_valid    = exec && (cur_op == OP_OUT_A) && active;
    out_data     = a_q[W-1:0];
    a_wr         = fin && (cur_op == OP_IN_A) && (verdict == V_DO || verdict == V_EXIT);
    a_wdata      = (verdict == V_DO) ? {{UPPER{1'b0}}, in_data} : '0;
    eq_act       = fin && (cur_op == OP_ACT)   && (verdict == V_DO);
    eq_inact     = fin && (cur_op == OP_DEACT) && (verdict == V_DO);
    eq_func      = fin && (cur_op == OP_FUNC_A || cur_op == OP_FUNC_M) && (verdict == V_DO);
    eq_func_code = (cur_op == OP_FUNC_M) ? m_q : a_q[W-1:0];
    own_set      = eq_act;
    own_clr      = eq_inact;
  end
endmodule

// File: rtl/chctl_top.sv
module chctl_top
  import chctl_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 18,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [2:0]    instr_op,
  input  logic          instr_nohang,
  input  logic [W-1:0]  instr_m,
  input  logic [PW-1:0] instr_p,
  input  logic [AW-1:0] a_in,
  output logic          a_wr,
  output logic [AW-1:0] a_wdata,
  output logic          done,
  output logic [PW-1:0] next_p,
  output logic          stall,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  input  logic          ext_act,
  input  logic          ext_deact,
  output logic          ch_active,
  output logic          eq_act,
  output logic          eq_inact,
  output logic          eq_func,
  output logic [W-1:0]  eq_func_code
);
  logic [2:0] cur_op;
  logic       cur_nohang;
  logic       own_set, own_clr;
  verdict_e   verdict;

  chctl_flag u_flag (
    .clk(clk), .rst_n(rst_n), .own_set(own_set), .own_clr(own_clr),
    .ext_act(ext_act), .ext_deact(ext_deact), .active(ch_active)
  );

  chctl_judge u_judge (
    .op(cur_op), .nohang(cur_nohang), .active(ch_active),
    .full(in_valid), .sink_ready(out_ready), .verdict(verdict)
  );

  chctl_seq #(.W(W), .AW(AW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_nohang(instr_nohang),
    .instr_m(instr_m), .instr_p(instr_p), .a_in(a_in),
    .active(ch_active), .in_data(in_data), .verdict(verdict),
    .cur_op(cur_op), .cur_nohang(cur_nohang),
    .a_wr(a_wr), .a_wdata(a_wdata), .done(done), .next_p(next_p),
    .stall(stall), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .own_set(own_set), .own_clr(own_clr),
    .eq_act(eq_act), .eq_inact(eq_inact), .eq_func(eq_func),
    .eq_func_code(eq_func_code)
  );
endmodule

// File: rtl/chctl_chk.sv
module chctl_chk #(
  parameter int W  = 12,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_ready,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic          out_valid,
  input logic          a_wr,
  input logic [AW-1:0] a_wdata,
  input logic          done,
  input logic          stall,
  input logic          ext_deact,
  input logic          ch_active,
  input logic          eq_act,
  input logic          eq_inact,
  input logic          eq_func
);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eq_act, eq_inact, eq_func}));
  p_done_not_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stall));
  p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> instr_ready);
  p_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (a_wr && a_wdata == {{(AW-W){1'b0}}, in_data}));
  p_a_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |-> (a_wdata[AW-1:W] == '0));
  p_out_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ch_active);
  p_act_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eq_act |-> !ch_active);
  p_act_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_act && !ext_deact) |=> ch_active);
  p_inact_from_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eq_inact |-> ch_active);
  p_inact_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eq_inact |=> !ch_active);
  p_func_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eq_func |-> !ch_active);
  p_ext_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_deact |=> !ch_active);
endmodule

bind chctl_top chctl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .a_wr(a_wr), .a_wdata(a_wdata),
  .done(done), .stall(stall), .ext_deact(ext_deact),
  .ch_active(ch_active), .eq_act(eq_act), .eq_inact(eq_inact),
  .eq_func(eq_func)
);

// File: tb/chctl_top_tb.sv
`timescale 1ns/1ps
module chctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [2:0]  instr_op = '0;
  logic        instr_nohang = 1'b0;
  logic [11:0] instr_m = 12'h456;
  logic [11:0] instr_p = 12'h100;
  logic [17:0] a_in = 18'h3F123;
  logic        a_wr;
  logic [17:0] a_wdata;
  logic        done;
  logic [11:0] next_p;
  logic        stall;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = 12'hA5C;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_data;
  logic        ext_act = 1'b0;
  logic        ext_deact = 1'b0;
  logic        ch_active;
  logic        eq_act, eq_inact, eq_func;
  logic [11:0] eq_func_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  chctl_top u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_chan(input bit on);
    @(negedge clk);
    ext_act = on; ext_deact = !on;
    @(negedge clk);
    ext_act = 1'b0; ext_deact = 1'b0;
  endtask

  // drive an instruction, return at the negedge of the first execute cycle
  task automatic issue(input logic [2:0] op, input bit nh);
    @(negedge clk);
    instr_op = op; instr_nohang = nh; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // vector: [12]chan active [11:9]op [8]nohang [7]in_valid [6]out_ready
  //         [5:3]strobes act,inact,func [2]A written [1]two-word [0]A zero
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b1}, // R4 exit
    {1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0}, // R2
    {1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0}, // R5
    {1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0, 1'b0}, // R6
    {1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0}, // R6 skip
    {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0, 1'b0}, // R7
    {1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0}, // R7 skip
    {1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 1'b0, 1'b0}, // R8 A form
    {1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 1'b0}, // R8 m form
    {1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0}, // R9 skip A
    {1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0}, // R9 skip m
    {1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0}  // R2 nohang
  };

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(instr_ready === 1'b1, "R11 ready", instr_ready, 1);
    chk(ch_active === 1'b0, "R11 flag", ch_active, 0);
    chk({done, stall, eq_act, eq_inact, eq_func} === 5'b0, "R11 quiet",
        {done, stall, eq_act, eq_inact, eq_func}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [12:0] v;
      logic [17:0] exp_a;
      v = VEC[i];
      set_chan(v[12]);
      in_valid = v[7]; out_ready = v[6];
      issue(v[11:9], v[8]);
      exp_a = v[0] ? 18'h0 : {6'h0, in_data};
      chk(done === 1'b1 && stall === 1'b0, $sformatf("R12 vec%0d done", i), {done, stall}, 2'b10);
      chk(next_p === (v[1] ? 12'h102 : 12'h101), $sformatf("R9 vec%0d next_p", i), next_p, v[1] ? 12'h102 : 12'h101);
      chk({eq_act, eq_inact, eq_func} === v[5:3], $sformatf("R6 vec%0d strobes", i), {eq_act, eq_inact, eq_func}, v[5:3]);
      chk(a_wr === v[2], $sformatf("R4 vec%0d a_wr", i), a_wr, v[2]);
      if (v[2]) chk(a_wdata === exp_a, $sformatf("R2 vec%0d A", i), a_wdata, exp_a);
      if (v[3]) chk(eq_func_code === (v[1] ? 12'h456 : 12'h123), $sformatf("R8 vec%0d code", i),
                    eq_func_code, v[1] ? 12'h456 : 12'h123);
      if (v[11:9] == 3'd1) chk(out_valid === 1'b1 && out_data === 12'h123, "R5 out word", out_data, 12'h123);
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      chk(instr_ready === 1'b1, $sformatf("R1 vec%0d idle", i), instr_ready, 1);
    end

    // R3: input waits for active and full
    set_chan(1'b0);
    in_valid = 1'b1;
    issue(3'd0, 1'b0);
    repeat (3) begin
      chk(stall === 1'b1 && done === 1'b0 && in_ready === 1'b0, "R3 held", {stall, done, in_ready}, 3'b100);
      @(negedge clk);
    end
    chk(instr_ready === 1'b0, "R1 busy while held", instr_ready, 0);
    ext_act = 1'b1; @(negedge clk); ext_act = 1'b0;
    chk(done === 1'b1 && a_wdata === 18'h00A5C, "R3 released", a_wdata, 18'h00A5C);
    @(negedge clk); in_valid = 1'b0;

    // R4: deactivated before a word arrives
    issue(3'd0, 1'b1);
    chk(stall === 1'b1, "R4 waits for word", stall, 1);
    ext_deact = 1'b1; @(negedge clk); ext_deact = 1'b0;
    chk(done === 1'b1 && a_wr === 1'b1 && a_wdata === 18'h0, "R4 exit clears A", a_wdata, 0);
    @(negedge clk);

    // R5: back-pressure on output
    set_chan(1'b1);
    issue(3'd1, 1'b0);
    repeat (2) begin
      chk(stall === 1'b1 && out_valid === 1'b1 && out_data === 12'h123, "R5 held valid", out_data, 12'h123);
      @(negedge clk);
    end
    out_ready = 1'b1; #0.1;
    chk(done === 1'b1 && next_p === 12'h101, "R5 completes", next_p, 12'h101);
    @(negedge clk); out_ready = 1'b0;

    // R6: activate on active channel, bit clear, released by external deactivate
    issue(3'd2, 1'b0);
    chk(stall === 1'b1 && eq_act === 1'b0, "R6 held", stall, 1);
    ext_deact = 1'b1; @(negedge clk); ext_deact = 1'b0;
    chk(done === 1'b1 && eq_act === 1'b1, "R10 release activates", eq_act, 1);
    @(negedge clk);
    chk(ch_active === 1'b1, "R6 flag set", ch_active, 1);

    // R7: deactivate on inactive channel waits for activation
    set_chan(1'b0);
    issue(3'd3, 1'b0);
    chk(stall === 1'b1 && eq_inact === 1'b0, "R7 held", stall, 1);
    ext_act = 1'b1; @(negedge clk); ext_act = 1'b0;
    chk(done === 1'b1 && eq_inact === 1'b1, "R7 released", eq_inact, 1);
    @(negedge clk);
    chk(ch_active === 1'b0, "R7 flag clear", ch_active, 0);

    // R9: function on active channel, bit clear, held then sent
    set_chan(1'b1);
    issue(3'd5, 1'b0);
    chk(stall === 1'b1 && eq_func === 1'b0, "R9 held", eq_func, 0);
    ext_deact = 1'b1; @(negedge clk); ext_deact = 1'b0;
    chk(eq_func === 1'b1 && eq_func_code === 12'h456 && next_p === 12'h102, "R9 released", eq_func_code, 12'h456);
    @(negedge clk);

    // R1: unused code finishes at P+1 with no effect
    issue(3'd7, 1'b0);
    chk(done === 1'b1 && next_p === 12'h101 && a_wr === 1'b0, "R1 unused code", next_p, 12'h101);
    @(negedge clk);

    // R10: external deactivate wins over external activate
    @(negedge clk); ext_act = 1'b1; ext_deact = 1'b1;
    @(negedge clk); ext_act = 1'b0; ext_deact = 1'b0;
    chk(ch_active === 1'b0, "R10 priority", ch_active, 0);

    summary();
  end
endmodule